// File: doc/BRIEF.md
# Display Interrupt Status and Identification Unit

This unit gathers the interrupt-worthy events of a display controller's frame-fetch engine and turns them into one level-sensitive interrupt line. Each event pulse (frame start, frame end, branch taken or bus error on any of the fetch channels, plus a handful of controller-wide conditions) sets a sticky bit in one of two status registers. Software clears the bits by writing ones to them over a small register bus. Mask registers stop selected bits from driving the interrupt.

A frame-ID register identifies the event that opened an interrupt episode. When an unmasked channel event arrives while the interrupt line is low, the register takes that channel's frame ID. When the line is already high, the ID is kept and a secondary-interrupt status bit is set instead. If several channels qualify in the same cycle, the lowest-numbered one supplies the ID and the secondary bit is also set. A bus error always takes part in this rule, whatever the masks say. The event sources are outside this unit.

Top module: `lcd_irq_unit`

## Requirements
- R1: Primary status bits are set by event pulses at these positions: 0 last frame done, 1 frame start ch0, 2 bus error, 3 bias count, 4 underrun ch0, 5 underrun ch1, 6 output underrun, 7 quick disable, 8 frame end ch0, 9 branch ch0, 10 secondary interrupt, 11 read status, 12 command done. A set bit stays set until it is cleared.
- R2: For a channel c from 1 upward, the channel status register holds frame start at bit c-1, frame end at bit c+7 and branch at bit c+15.
- R3: irq is registered. One cycle after the status or mask registers change, it equals the OR of the primary status bits {0,1,4,5,6,7,8,9,11,12} whose mask0 bit at the same position is 0, ORed with any channel status bit whose mask1 bit is 0.
- R4: An unmasked frame start, frame end or branch event that arrives while irq is 0 loads that channel's frame ID into the ID register. The ch0 events are masked by mask0 bits 1, 8 and 9. The events of channel c≥1 are masked by mask1 at their R2 positions.
- R5: An unmasked channel event that arrives while irq is 1 sets primary bit 10 and leaves the ID register unchanged.
- R6: A masked channel event still sets its status bit, but it changes neither the ID register nor bit 10.
- R7: A bus error on channel c sets primary bit 2 and writes c into primary bits [30:28]. It applies the ID/secondary rule of R4 and R5 regardless of any mask.
- R8: Writing the primary status register clears those of bits [11:0] that are written as 1. Bit 12 cannot be cleared. Writing 1 to bit 2 also clears the channel field [30:28].
- R9: Writing the channel status register clears the bits written as 1 only within mask 0x003E3F3F, so bit 16 cannot be cleared.
- R10: A write to the control register (address 0, bit 0 enable) that changes enable from 1 to 0 sets primary bit 7.
- R11: When several channels qualify in one cycle while irq is 0, the lowest channel's ID is loaded and bit 10 is set.
- R12: An event arriving in the same cycle as a clear write to its bit leaves the bit set.
- R13: Addresses are 0 control, 1 mask0, 2 mask1, 3 primary status, 4 channel status, 5 frame ID (read only). bus_rdata shows the addressed register one cycle after the address is presented. After reset, every register reads 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| ev_sof | input | NCH | Frame-start pulse per channel |
| ev_eof | input | NCH | Frame-end pulse per channel |
| ev_bs | input | NCH | Branch-taken pulse per channel |
| ev_ber | input | NCH | Bus-error pulse per channel |
| ev_ldd | input | 1 | Last frame done pulse |
| ev_abc | input | 1 | Bias-count pulse |
| ev_uf0 | input | 1 | Input underrun ch0 pulse |
| ev_uf1 | input | 1 | Input underrun ch1 pulse |
| ev_ou | input | 1 | Output underrun pulse |
| ev_rdst | input | 1 | Read-status pulse |
| ev_cmd | input | 1 | Command-done pulse |
| fid_flat | input | NCH*IDW | Frame IDs, channel c at [c*IDW +: IDW] |
| irq | output | 1 | Level interrupt |

## Verification
Any disagreement between the registered irq and the status and mask registers shows on the irq pin one cycle after the update that caused it. A wrong choice in the ID or secondary decision does not show on any pin right away. It is stored, and it appears only when the frame-ID or primary status register is read back. For that reason every event scenario ends with reads of those registers. A lost or wrongly cleared sticky bit is likewise seen only at the next status read. The clear-mask quirks (bit 12 and channel bit 16) are therefore read back directly after a write of all ones.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;
  typedef enum logic [2:0] {
    A_CTL   = 3'd0,
    A_MASK0 = 3'd1,
    A_MASK1 = 3'd2,
    A_STAT0 = 3'd3,
    A_STAT1 = 3'd4,
    A_FID   = 3'd5
  } reg_addr_e;

  localparam int S0W      = 13;
  localparam int BERF_LSB = 28;

  localparam int B_LDD  = 0;
  localparam int B_SOF0 = 1;
  localparam int B_BER  = 2;
  localparam int B_ABC  = 3;
  localparam int B_UF0  = 4;
  localparam int B_UF1  = 5;
  localparam int B_OU   = 6;
  localparam int B_QD   = 7;
  localparam int B_EOF0 = 8;
  localparam int B_BS0  = 9;
  localparam int B_SINT = 10;
  localparam int B_RDST = 11;
  localparam int B_CMD  = 12;

  // primary bits that may raise the interrupt line
  localparam logic [S0W-1:0] S0_IRQ_SRC = 13'b1_1011_1111_0011;
  localparam logic [31:0]    S1_CLR     = 32'h003E_3F3F;
  localparam int             S0_CLRW    = 12;

  localparam int EOF_OFS = 7;
  localparam int BS_OFS  = 15;
endpackage

// File: rtl/lcd_irq_chan_gate.sv
module lcd_irq_chan_gate
  import lcd_irq_pkg::*;
#(
  parameter int NCH = 7,
  parameter int S1W = 32
) (
  input  logic [NCH-1:0] ev_sof,
  input  logic [NCH-1:0] ev_eof,
  input  logic [NCH-1:0] ev_bs,
  input  logic [NCH-1:0] ev_ber,
  input  logic [2:0]     m0_ch0,   // {branch, end, start} masks of ch0
  input  logic [S1W-1:0] mask1,
  output logic [NCH-1:0] qual,
  output logic [S1W-1:0] s1_set
);
  logic unused_mask1;
  assign unused_mask1 = ^mask1;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      if (c == 0) begin : g_prim
        assign qual[c] = (ev_sof[c] & ~m0_ch0[0]) | (ev_eof[c] & ~m0_ch0[1]) |
                         (ev_bs[c] & ~m0_ch0[2]) | ev_ber[c];
      end else begin : g_sec
        assign qual[c] = (ev_sof[c] & ~mask1[c-1]) |
                         (ev_eof[c] & ~mask1[c+EOF_OFS]) |
                         (ev_bs[c] & ~mask1[c+BS_OFS]) | ev_ber[c];
      end
    end
  endgenerate

  always_comb begin
    s1_set = '0;
    for (int k = 1; k < NCH; k++) begin
      s1_set[k-1]       = ev_sof[k];
      s1_set[k+EOF_OFS] = ev_eof[k];
      s1_set[k+BS_OFS]  = ev_bs[k];
    end
  end
endmodule

// File: rtl/lcd_irq_id_arb.sv
module lcd_irq_id_arb #(
  parameter int NCH = 7,
  parameter int CHW = 3
) (
  input  logic [NCH-1:0] qual,
  input  logic [NCH-1:0] ev_ber,
  input  logic           irq_now,
  output logic           cap_en,
  output logic [CHW-1:0] cap_ch,
  output logic           sint_set,
  output logic           ber_any,
  output logic [CHW-1:0] ber_ch
);
  logic any_q, multi_q;

  always_comb begin
    cap_ch = '0;
    ber_ch = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (qual[c])   cap_ch = CHW'(c);
      if (ev_ber[c]) ber_ch = CHW'(c);
    end
    any_q    = |qual;
    multi_q  = |(qual & (qual - NCH'(1)));
    ber_any  = |ev_ber;
    cap_en   = any_q & ~irq_now;
    sint_set = (any_q & irq_now) | multi_q;
  end
endmodule

// File: rtl/lcd_irq_unit.sv
module lcd_irq_unit
  import lcd_irq_pkg::*;
#(
  parameter int NCH = 7,
  parameter int IDW = 32,
  parameter int DW  = 32,
  parameter int AW  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NCH-1:0]   ev_sof,
  input  logic [NCH-1:0]   ev_eof,
  input  logic [NCH-1:0]   ev_bs,
  input  logic [NCH-1:0]   ev_ber,
  input  logic             ev_ldd,
  input  logic             ev_abc,
  input  logic             ev_uf0,
  input  logic             ev_uf1,
  input  logic             ev_ou,
  input  logic             ev_rdst,
  input  logic             ev_cmd,
  input  logic [NCH*IDW-1:0] fid_flat,
  output logic             irq
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int S1W = DW;

  logic             ctl_en;
  logic [S0W-1:0]   mask0, stat0, set0, clr0;
  logic [S1W-1:0]   mask1, stat1, s1_set, clr1;
  logic [CHW-1:0]   ber_ch_q, cap_ch, ber_ch;
  logic [IDW-1:0]   fid_q;
  logic [NCH-1:0]   qual;
  logic             cap_en, sint_set, ber_any, qd_evt, irq_q, level;
  logic             wr_ctl, wr_m0, wr_m1, wr_s0, wr_s1;

  assign wr_ctl = bus_wr && (bus_addr == AW'(A_CTL));
  assign wr_m0  = bus_wr && (bus_addr == AW'(A_MASK0));
  assign wr_m1  = bus_wr && (bus_addr == AW'(A_MASK1));
  assign wr_s0  = bus_wr && (bus_addr == AW'(A_STAT0));
  assign wr_s1  = bus_wr && (bus_addr == AW'(A_STAT1));
  assign qd_evt = wr_ctl && ctl_en && !bus_wdata[0];

  lcd_irq_chan_gate #(.NCH(NCH), .S1W(S1W)) u_gate (
    .ev_sof (ev_sof),
    .ev_eof (ev_eof),
    .ev_bs  (ev_bs),
    .ev_ber (ev_ber),
    .m0_ch0 ({mask0[B_BS0], mask0[B_EOF0], mask0[B_SOF0]}),
    .mask1  (mask1),
    .qual   (qual),
    .s1_set (s1_set)
  );

  lcd_irq_id_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .qual     (qual),
    .ev_ber   (ev_ber),
    .irq_now  (irq_q),
    .cap_en   (cap_en),
    .cap_ch   (cap_ch),
    .sint_set (sint_set),
    .ber_any  (ber_any),
    .ber_ch   (ber_ch)
  );

  always_comb begin
    set0         = '0;
    set0[B_LDD]  = ev_ldd;
    set0[B_SOF0] = ev_sof[0];
    set0[B_BER]  = ber_any;
    set0[B_ABC]  = ev_abc;
    set0[B_UF0]  = ev_uf0;
    set0[B_UF1]  = ev_uf1;
    set0[B_OU]   = ev_ou;
    set0[B_QD]   = qd_evt;
    set0[B_EOF0] = ev_eof[0];
    set0[B_BS0]  = ev_bs[0];
    set0[B_SINT] = sint_set;
    set0[B_RDST] = ev_rdst;
    set0[B_CMD]  = ev_cmd;
    clr0 = '0;
    if (wr_s0) clr0[S0_CLRW-1:0] = bus_wdata[S0_CLRW-1:0];
    clr1 = wr_s1 ? (bus_wdata & S1W'(S1_CLR)) : '0;
    level = (|(stat0 & ~mask0 & S0_IRQ_SRC)) | (|(stat1 & ~mask1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en   <= 1'b0;
      mask0    <= '0;
      mask1    <= '0;
      stat0    <= '0;
      stat1    <= '0;
      ber_ch_q <= '0;
      fid_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctl) ctl_en <= bus_wdata[0];
      if (wr_m0)  mask0  <= bus_wdata[S0W-1:0];
      if (wr_m1)  mask1  <= bus_wdata;
      stat0 <= (stat0 & ~clr0) | set0;
      stat1 <= (stat1 & ~clr1) | s1_set;
      if (ber_any)                      ber_ch_q <= ber_ch;
      else if (wr_s0 && bus_wdata[B_BER]) ber_ch_q <= '0;
      if (cap_en) fid_q <= fid_flat[cap_ch*IDW +: IDW];
      irq_q <= level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      case (bus_addr)
        AW'(A_CTL):   bus_rdata[0] <= ctl_en;
        AW'(A_MASK0): bus_rdata[S0W-1:0] <= mask0;
        AW'(A_MASK1): bus_rdata <= mask1;
        AW'(A_STAT0): begin
          bus_rdata[S0W-1:0]         <= stat0;
          bus_rdata[BERF_LSB +: CHW] <= ber_ch_q;
        end
        AW'(A_STAT1): bus_rdata <= stat1;
        AW'(A_FID):   bus_rdata <= DW'(fid_q);
        default:      bus_rdata <= '0;
      endcase
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/lcd_irq_unit_chk.sv
module lcd_irq_unit_chk
  import lcd_irq_pkg::*;
#(
  parameter int NCH = 7,
  parameter int IDW = 32,
  parameter int DW  = 32,
  parameter int AW  = 3,
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           irq,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic           ctl_en,
  input logic [S0W-1:0] stat0,
  input logic [DW-1:0]  stat1,
  input logic [S0W-1:0] mask0,
  input logic [DW-1:0]  mask1,
  input logic [CHW-1:0] ber_ch_q,
  input logic [IDW-1:0] fid_q,
  input logic [NCH-1:0] qual
);
  logic wr_s1_c, qd_c, all_masked;
  assign wr_s1_c    = bus_wr && (bus_addr == AW'(A_STAT1));
  assign qd_c       = bus_wr && (bus_addr == AW'(A_CTL)) && ctl_en && !bus_wdata[0];
  assign all_masked = (&(mask0 | ~S0_IRQ_SRC)) && (&mask1);

  // R2: channel status bits only fall through a clear write
  p_stat1_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_s1_c) |-> ((stat1 & $past(stat1)) == $past(stat1)));

  // R3: everything masked keeps the line low
  p_all_masked_r3: assert property (@(posedge clk) disable iff (rst)
    $past(all_masked) |-> !irq);

  // R5: ID register moves only while the line was low
  p_fid_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(fid_q) |-> !$past(irq));

  // R5: event during an open episode marks the secondary bit
  p_sint_busy_r5: assert property (@(posedge clk) disable iff (rst)
    $past(irq && (|qual)) |-> stat0[B_SINT]);

  // R7: a nonzero channel field implies the bus-error bit
  p_berf_r7: assert property (@(posedge clk) disable iff (rst)
    (ber_ch_q != '0) |-> stat0[B_BER]);

  // R8: command bit never drops
  p_cmd_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(stat0[B_CMD]) |-> stat0[B_CMD]);

  // R10: disabling an enabled controller flags quick disable
  p_qd_r10: assert property (@(posedge clk) disable iff (rst)
    $past(qd_c) |-> stat0[B_QD]);
endmodule

bind lcd_irq_unit lcd_irq_unit_chk #(
  .NCH(NCH), .IDW(IDW), .DW(DW), .AW(AW), .CHW(CHW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ctl_en    (ctl_en),
  .stat0     (stat0),
  .stat1     (stat1),
  .mask0     (mask0),
  .mask1     (mask1),
  .ber_ch_q  (ber_ch_q),
  .fid_q     (fid_q),
  .qual      (qual)
);

// File: tb/test_lcd_irq_unit.sv
`timescale 1ns/1ps
module test_lcd_irq_unit;
  localparam int NCH = 7;
  localparam int IDW = 32;
  localparam int DW  = 32;
  localparam int AW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NCH-1:0] ev_sof = '0, ev_eof = '0, ev_bs = '0, ev_ber = '0;
  logic ev_ldd = 0, ev_abc = 0, ev_uf0 = 0, ev_uf1 = 0, ev_ou = 0, ev_rdst = 0, ev_cmd = 0;
  logic [NCH*IDW-1:0] fid_flat;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic rd_req = 0, rd_pend = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  lcd_irq_unit #(.NCH(NCH), .IDW(IDW), .DW(DW), .AW(AW)) i_lcd_irq_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_bs(ev_bs), .ev_ber(ev_ber),
    .ev_ldd(ev_ldd), .ev_abc(ev_abc), .ev_uf0(ev_uf0), .ev_uf1(ev_uf1),
    .ev_ou(ev_ou), .ev_rdst(ev_rdst), .ev_cmd(ev_cmd),
    .fid_flat(fid_flat), .irq(irq)
  );

  function automatic logic [31:0] fid(input int c);
    return 32'h5A00_0000 | ((c + 1) * 32'h111);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data from the scoreboard
  always @(posedge clk) rd_pend <= rd_req;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata === e, t, bus_rdata, e);
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    rd_req = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] s, e, b, be, input logic [6:0] misc);
    @(negedge clk);
    ev_sof = s; ev_eof = e; ev_bs = b; ev_ber = be;
    {ev_cmd, ev_rdst, ev_ou, ev_uf1, ev_uf0, ev_abc, ev_ldd} = misc;
    @(negedge clk);
    ev_sof = '0; ev_eof = '0; ev_bs = '0; ev_ber = '0;
    {ev_cmd, ev_rdst, ev_ou, ev_uf1, ev_uf0, ev_abc, ev_ldd} = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    chk(irq === e, t, {31'd0, irq}, {31'd0, e});
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) fid_flat[c*IDW +: IDW] = fid(c);
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    for (int a = 0; a < 6; a++) rd(AW'(a), '0, "R13 reset value");
    chk_irq(1'b0, "R13 irq after reset");

    // R2/R3/R4 first unmasked event opens an episode
    pulse(7'b0000100, '0, '0, '0, '0);
    chk_irq(1'b1, "R3 irq follows status");
    rd(3'd4, 32'h2, "R2 ch2 start bit");
    rd(3'd5, fid(2), "R4 ID captured");
    rd(3'd3, 32'h0, "R4 no secondary");

    // R5 event while line is high
    pulse('0, 7'b0000001, '0, '0, '0);
    rd(3'd3, 32'h0000_0500, "R5 secondary and ch0 end");
    rd(3'd5, fid(2), "R5 ID kept");

    // R8/R9 clears, R3 line falls
    wr(3'd3, 32'h0000_0FFF);
    wr(3'd4, 32'h0000_0002);
    rd(3'd3, 32'h0, "R8 primary cleared");
    rd(3'd4, 32'h0, "R9 channel cleared");
    chk_irq(1'b0, "R3 irq released");

    // R6 masked channel event
    wr(3'd2, 32'h0000_0400);
    pulse('0, 7'b0001000, '0, '0, '0);
    chk_irq(1'b0, "R6 masked keeps irq low");
    rd(3'd4, 32'h0000_0400, "R6 status still set");
    rd(3'd5, fid(2), "R6 ID unchanged");
    rd(3'd3, 32'h0, "R6 no secondary");
    wr(3'd4, 32'h0000_0400);
    wr(3'd2, 32'h0);

    // R3 mask0 gating on primary bit 0
    wr(3'd1, 32'h1);
    pulse('0, '0, '0, '0, 7'b0000001);
    chk_irq(1'b0, "R3 masked primary bit");
    wr(3'd1, 32'h0);
    chk_irq(1'b1, "R3 unmask raises irq");
    wr(3'd3, 32'h1);
    chk_irq(1'b0, "R3 irq low before R11");

    // R11 simultaneous channels
    pulse(7'b0100000, 7'b0010000, 7'b0000010, '0, '0);
    rd(3'd5, fid(1), "R11 lowest channel ID");
    rd(3'd3, 32'h0000_0400, "R11 secondary set");
    rd(3'd4, 32'h0001_0810, "R2 channel positions");

    // R9 bit 16 survives
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'h0001_0000, "R9 clear mask");

    // R7 bus error ignores masks
    wr(3'd1, 32'h0000_1FFF);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0000_0FFF);
    chk_irq(1'b0, "R3 all masked");
    pulse('0, '0, '0, 7'b0001000, '0);
    rd(3'd3, 32'h3000_0004, "R7 bit and field");
    rd(3'd5, fid(3), "R7 ID despite masks");
    chk_irq(1'b0, "R7 bus error not an irq source");
    wr(3'd3, 32'h0000_0004);
    rd(3'd3, 32'h0, "R8 field cleared");

    // R8 bit 12 not clearable
    pulse('0, '0, '0, '0, 7'b1000000);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, 32'h0000_1000, "R8 command bit sticky");

    // R10 quick disable
    wr(3'd0, 32'h1);
    rd(3'd0, 32'h1, "R10 enable readback");
    rd(3'd3, 32'h0000_1000, "R10 no flag yet");
    wr(3'd0, 32'h0);
    rd(3'd3, 32'h0000_1080, "R10 quick disable flag");

    // R12 set beats clear
    @(negedge clk);
    bus_addr = 3'd3; bus_wdata = 32'h40; bus_wr = 1'b1; ev_ou = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ev_ou = 1'b0;
    rd(3'd3, 32'h0000_10C0, "R12 set wins");

    // R1 remaining primary events
    pulse('0, '0, '0, '0, 7'b0101110);
    rd(3'd3, 32'h0000_18F8, "R1 primary positions");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule